// File: doc/BRIEF.md
# Cycle-Stealing Single-Channel Transfer Engine

This block moves data between a peripheral location and a memory buffer on behalf of one requester, one item at a time. Each time the requester raises its request while the channel is active, the engine spends one cycle deciding to serve it. It then reads one item from the source over a simple master port with a ready handshake and writes that item to the destination. After the write it gives the bus back, so other masters can use the bus between items. It never holds the bus for a burst.

Software-visible settings are taken as plain inputs and captured when the enable input rises. These settings are the direction, the item size, a separate increment enable for each pointer, a wrap-around (circular) mode and the item count. The engine pulses an acknowledge to the requester once the read has landed. In one-shot mode it raises a sticky completion flag after the last item. In circular mode it rewinds its count and pointers and keeps going. A bus error in either phase stops the channel and raises a sticky error flag.

Top module: `cyc_steal_dma`

## Requirements
- R1: A request seen while the channel is active and idle spends one cycle with bus_valid low. The engine then issues a read (bus_write=0) at the source pointer, and after that read's handshake a write (bus_write=1) of the captured bus_rdata at the destination pointer.
- R2: One request moves exactly one item. After every write handshake, bus_valid is low for at least one cycle.
- R3: While bus_valid is high and bus_ready is low, bus_addr, bus_write, bus_size and bus_wdata hold their values.
- R4: cfg_dir=0 makes the peripheral pointer the source and the memory pointer the destination. cfg_dir=1 swaps the two roles.
- R5: After each successful write, a pointer whose increment enable is set advances by the item size in bytes. The size field cfg_size encodes 0 as byte (step 1), 1 as halfword (step 2), 2 as word (step 4), and 3 is treated as word. A pointer whose increment enable is clear holds its value. bus_size carries the captured cfg_size.
- R6: The item count is captured at enable, and a captured count of 0 means 2**CNT_W items. In one-shot mode (cfg_circ=0), the channel stops after the last item's write and done_o stays high until the next rising edge of cfg_en. Requests made after that point cause no bus access.
- R7: In circular mode (cfg_circ=1), after the last item the count and both pointers return to their captured start values, transfers continue, and done_o stays low.
- R8: bus_err is sampled together with bus_ready in either phase. On an error the item is dropped, the channel stops, neither pointer nor count advances, and err_o stays high until the next rising edge of cfg_en.
- R9: ack_o is high for exactly one cycle, in the cycle after a read handshake without error. A read error produces no ack_o.
- R10: During and after reset, bus_valid, ack_o, done_o and err_o are low and the channel is inactive.
- R11: All cfg_* values other than cfg_en are captured on the rising edge of cfg_en. Changing them while the channel is enabled has no effect on addresses, sizes or counts.
- R12: Dropping cfg_en stops new items from starting. An item already on the bus runs to completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_en | input | 1 | Channel enable; rising edge captures settings |
| cfg_dir | input | 1 | 0: peripheral to memory, 1: memory to peripheral |
| cfg_pinc | input | 1 | Peripheral pointer increment enable |
| cfg_minc | input | 1 | Memory pointer increment enable |
| cfg_size | input | 2 | Item size code (0 byte, 1 halfword, 2/3 word) |
| cfg_circ | input | 1 | Circular mode |
| cfg_count | input | CNT_W | Item count, 0 means 2**CNT_W |
| cfg_pbase | input | AW | Peripheral start address |
| cfg_mbase | input | AW | Memory start address |
| req_i | input | 1 | Transfer request level |
| ack_o | output | 1 | One-cycle acknowledge after the read phase |
| bus_valid | output | 1 | Bus access in progress |
| bus_write | output | 1 | 1 write, 0 read |
| bus_size | output | 2 | Access size code |
| bus_addr | output | AW | Access address |
| bus_wdata | output | DW | Write data |
| bus_rdata | input | DW | Read data, valid with bus_ready |
| bus_ready | input | 1 | Access completes this cycle |
| bus_err | input | 1 | Error response, valid with bus_ready |
| done_o | output | 1 | Sticky completion flag (one-shot mode) |
| err_o | output | 1 | Sticky bus-error flag |

## Verification
The engine is tried with short request pulses and with a request held high. The first shows that one item moves per acknowledge. The second shows that the bus is released between back-to-back items. Runs with bus_ready always high are set against runs with a pseudo-random ready pattern: the first pins down the exact phase timing, and the second proves that the address and data hold under wait states. Direction, item size and increment patterns are varied so that a swapped pointer or a wrong step shows up as an address mismatch. Count runs with a nonzero value, a zero value and a circular wrap separate the stop, the full-range and the rewind behaviour. Errors injected in the read phase and in the write phase separate the acknowledge and no-acknowledge cases.

// File: rtl/csd_pkg.sv
package csd_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ARB  = 2'd1,
    PH_RD   = 2'd2,
    PH_WR   = 2'd3
  } csd_phase_e;

  // byte step for an item size code; code 3 is handled as a full word
  function automatic logic [2:0] csd_step(input logic [1:0] sz);
    case (sz)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/csd_ptr.sv
module csd_ptr #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] base,
  input  logic          rewind,
  input  logic          adv,
  input  logic          inc_en,
  input  logic [2:0]    step,
  output logic [AW-1:0] ptr
);

  logic [AW-1:0] base_q;
  logic [AW-1:0] ptr_q;
  logic [AW-1:0] ptr_d;
  logic          ptr_ce;

  always_comb begin
    ptr_ce = load | rewind | (adv & inc_en);
    if (load)        ptr_d = base;
    else if (rewind) ptr_d = base_q;
    else             ptr_d = ptr_q + {{(AW-3){1'b0}}, step};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      ptr_q  <= '0;
    end else begin
      if (load)   base_q <= base;
      if (ptr_ce) ptr_q  <= ptr_d;
    end
  end

  assign ptr = ptr_q;

endmodule

// File: rtl/csd_cnt.sv
module csd_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] count_cfg,
  input  logic             circ,
  input  logic             dec,
  output logic             wrap,
  output logic             finish
);

  localparam int RW = CNT_W + 1;

  logic [RW-1:0] rem_q;
  logic [RW-1:0] rem_d;
  logic [RW-1:0] reload_q;
  logic [RW-1:0] ld_val;
  logic          last;
  logic          rem_ce;

  always_comb begin
    ld_val = (count_cfg == '0) ? {1'b1, {CNT_W{1'b0}}} : {1'b0, count_cfg};
    last   = (rem_q == {{(RW-1){1'b0}}, 1'b1});
    wrap   = dec & last & circ;
    finish = dec & last & ~circ;
    rem_ce = load | dec;
    if (load)      rem_d = ld_val;
    else if (wrap) rem_d = reload_q;
    else           rem_d = rem_q - {{(RW-1){1'b0}}, 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q    <= '0;
      reload_q <= '0;
    end else begin
      if (load)   reload_q <= ld_val;
      if (rem_ce) rem_q    <= rem_d;
    end
  end

endmodule

// File: rtl/csd_seq.sv
module csd_seq
  import csd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       req,
  input  logic       bus_ready,
  input  logic       bus_err,
  output csd_phase_e phase,
  output logic       rd_done,
  output logic       wr_done,
  output logic       fail,
  output logic       ack
);

  csd_phase_e ph_q;
  csd_phase_e ph_d;
  logic       ack_q;

  always_comb begin
    ph_d    = ph_q;
    rd_done = 1'b0;
    wr_done = 1'b0;
    fail    = 1'b0;
    case (ph_q)
      PH_IDLE: if (run && req) ph_d = PH_ARB;
      PH_ARB:  ph_d = PH_RD;
      PH_RD: begin
        if (bus_ready) begin
          if (bus_err) begin
            fail = 1'b1;
            ph_d = PH_IDLE;
          end else begin
            rd_done = 1'b1;
            ph_d    = PH_WR;
          end
        end
      end
      PH_WR: begin
        if (bus_ready) begin
          ph_d = PH_IDLE;
          if (bus_err) fail    = 1'b1;
          else         wr_done = 1'b1;
        end
      end
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      ack_q <= 1'b0;
    end else begin
      ph_q  <= ph_d;
      ack_q <= rd_done;
    end
  end

  assign phase = ph_q;
  assign ack   = ack_q;

endmodule

// File: rtl/cyc_steal_dma.sv
module cyc_steal_dma
  import csd_pkg::*;
#(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_en,
  input  logic             cfg_dir,
  input  logic             cfg_pinc,
  input  logic             cfg_minc,
  input  logic [1:0]       cfg_size,
  input  logic             cfg_circ,
  input  logic [CNT_W-1:0] cfg_count,
  input  logic [AW-1:0]    cfg_pbase,
  input  logic [AW-1:0]    cfg_mbase,
  input  logic             req_i,
  output logic             ack_o,
  output logic             bus_valid,
  output logic             bus_write,
  output logic [1:0]       bus_size,
  output logic [AW-1:0]    bus_addr,
  output logic [DW-1:0]    bus_wdata,
  input  logic [DW-1:0]    bus_rdata,
  input  logic             bus_ready,
  input  logic             bus_err,
  output logic             done_o,
  output logic             err_o
);

  localparam int NPTR = 2;  // index 0: peripheral side, 1: memory side

  // reset: asserted asynchronously, released through two flops
  logic [1:0] rs_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sync_n = rs_q[1];

  // enable edge and captured settings
  logic       en_q;
  logic       en_rise;
  logic       dir_q, pinc_q, minc_q, circ_q;
  logic [1:0] size_q;

  assign en_rise = cfg_en & ~en_q;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      en_q   <= 1'b0;
      dir_q  <= 1'b0;
      pinc_q <= 1'b0;
      minc_q <= 1'b0;
      circ_q <= 1'b0;
      size_q <= 2'd0;
    end else begin
      en_q <= cfg_en;
      if (en_rise) begin
        dir_q  <= cfg_dir;
        pinc_q <= cfg_pinc;
        minc_q <= cfg_minc;
        circ_q <= cfg_circ;
        size_q <= cfg_size;
      end
    end
  end

  // sequencer
  csd_phase_e phase;
  logic       rd_done, wr_done, fail;
  logic       run_q, run_d;

  csd_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .run       (run_q),
    .req       (req_i),
    .bus_ready (bus_ready),
    .bus_err   (bus_err),
    .phase     (phase),
    .rd_done   (rd_done),
    .wr_done   (wr_done),
    .fail      (fail),
    .ack       (ack_o)
  );

  // item counter
  logic wrap, finish;

  csd_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .load      (en_rise),
    .count_cfg (cfg_count),
    .circ      (circ_q),
    .dec       (wr_done),
    .wrap      (wrap),
    .finish    (finish)
  );

  // address pointers
  logic [NPTR-1:0][AW-1:0] base_w;
  logic [NPTR-1:0][AW-1:0] ptr_w;
  logic [NPTR-1:0]         inc_w;
  logic [2:0]              step;

  assign base_w[0] = cfg_pbase;
  assign base_w[1] = cfg_mbase;
  assign inc_w[0]  = pinc_q;
  assign inc_w[1]  = minc_q;
  assign step      = csd_step(size_q);

  for (genvar gi = 0; gi < NPTR; gi++) begin : g_ptr
    csd_ptr #(.AW(AW)) u_ptr (
      .clk    (clk),
      .rst_n  (rst_sync_n),
      .load   (en_rise),
      .base   (base_w[gi]),
      .rewind (wrap),
      .adv    (wr_done),
      .inc_en (inc_w[gi]),
      .step   (step),
      .ptr    (ptr_w[gi])
    );
  end

  // channel state flags and data holding register
  logic          done_q, done_d, err_q, err_d;
  logic [DW-1:0] data_q;

  always_comb begin
    run_d  = run_q;
    done_d = done_q;
    err_d  = err_q;
    if (!cfg_en) run_d = 1'b0;
    if (en_rise) begin
      run_d  = 1'b1;
      done_d = 1'b0;
      err_d  = 1'b0;
    end
    if (fail) begin
      run_d = 1'b0;
      err_d = 1'b1;
    end
    if (finish) begin
      run_d  = 1'b0;
      done_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      run_q  <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      data_q <= '0;
    end else begin
      run_q  <= run_d;
      done_q <= done_d;
      err_q  <= err_d;
      if (rd_done) data_q <= bus_rdata;
    end
  end

  // master port
  logic [AW-1:0] src_addr, dst_addr;

  always_comb begin
    src_addr  = dir_q ? ptr_w[1] : ptr_w[0];
    dst_addr  = dir_q ? ptr_w[0] : ptr_w[1];
    bus_valid = (phase == PH_RD) || (phase == PH_WR);
    bus_write = (phase == PH_WR);
    bus_size  = size_q;
    case (phase)
      PH_RD:   bus_addr = src_addr;
      PH_WR:   bus_addr = dst_addr;
      default: bus_addr = '0;
    endcase
    bus_wdata = (phase == PH_WR) ? data_q : '0;
  end

  assign done_o = done_q;
  assign err_o  = err_q;

endmodule

// File: rtl/csd_chk.sv
module csd_chk #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_valid,
  input logic          bus_write,
  input logic          bus_ready,
  input logic          bus_err,
  input logic [AW-1:0] bus_addr,
  input logic [DW-1:0] bus_wdata,
  input logic [1:0]    bus_size,
  input logic          ack_o,
  input logic          done_o,
  input logic          err_o
);

  // R1
  read_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_valid) |-> !bus_write);

  // R1
  write_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write && bus_ready && !bus_err) |=> (bus_valid && bus_write));

  // R2
  bus_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_write && bus_ready) |=> !bus_valid);

  // R3
  wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_ready) |=> (bus_valid && $stable(bus_addr) && $stable(bus_write)
                                   && $stable(bus_wdata) && $stable(bus_size)));

  // R9
  ack_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |-> $past(bus_valid && !bus_write && bus_ready && !bus_err));

  // R8
  err_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_ready && bus_err) |=> (err_o && !bus_valid));

  // R6
  done_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> $past(bus_valid && bus_write && bus_ready && !bus_err));

endmodule

bind cyc_steal_dma csd_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .bus_valid (bus_valid),
  .bus_write (bus_write),
  .bus_ready (bus_ready),
  .bus_err   (bus_err),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_size  (bus_size),
  .ack_o     (ack_o),
  .done_o    (done_o),
  .err_o     (err_o)
);

// File: tb/cyc_steal_dma_test.sv
`timescale 1ns/1ps
module cyc_steal_dma_test;

  localparam int AW = 32;
  localparam int DW = 32;
  localparam int CW = 6;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cfg_en, cfg_dir, cfg_pinc, cfg_minc, cfg_circ;
  logic [1:0]    cfg_size;
  logic [CW-1:0] cfg_count;
  logic [AW-1:0] cfg_pbase, cfg_mbase;
  logic          req_i, ack_o;
  logic          bus_valid, bus_write, bus_ready, bus_err;
  logic [1:0]    bus_size;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata, bus_rdata;
  logic          done_o, err_o;

  int n_vec = 0;
  int n_bad = 0;

  always #10 clk = ~clk;  // 50 MHz

  cyc_steal_dma #(.AW(AW), .DW(DW), .CNT_W(CW)) uut (.*);

  function automatic logic [DW-1:0] data_of(input logic [AW-1:0] a);
    return {a[15:0] ^ 16'h5A3C, ~a[15:0]};
  endfunction

  assign bus_rdata = data_of(bus_addr);

  // ready pattern
  logic       rdy_rand = 1'b0;
  logic [7:0] lfsr = 8'hB7;
  always @(negedge clk) begin
    lfsr      <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    bus_ready <= rdy_rand ? (lfsr[1] | lfsr[4]) : 1'b1;
  end

  // ---------------- reference model ----------------
  int            m_ph;   // 0 idle, 1 deciding, 2 reading, 3 writing
  logic          m_run, m_done, m_err, m_ack, m_enq;
  logic          m_dir, m_pinc, m_minc, m_circ;
  logic [1:0]    m_size;
  logic [AW-1:0] m_pp, m_mp, m_pb, m_mb;
  logic [DW-1:0] m_data;
  int            m_rem, m_load;
  logic          err_arm = 1'b0;
  int            err_ph  = 2;

  assign bus_err = err_arm && (m_ph == err_ph);

  function automatic int stepb(input logic [1:0] s);
    return (s == 2'd0) ? 1 : (s == 2'd1) ? 2 : 4;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph <= 0; m_run <= 0; m_done <= 0; m_err <= 0; m_ack <= 0; m_enq <= 0;
      m_dir <= 0; m_pinc <= 0; m_minc <= 0; m_circ <= 0; m_size <= 0;
      m_pp <= 0; m_mp <= 0; m_pb <= 0; m_mb <= 0; m_data <= 0; m_rem <= 0; m_load <= 0;
    end else begin
      m_ack <= 1'b0;
      m_enq <= cfg_en;
      if (!cfg_en) m_run <= 1'b0;
      if (cfg_en && !m_enq) begin
        m_dir <= cfg_dir; m_pinc <= cfg_pinc; m_minc <= cfg_minc;
        m_circ <= cfg_circ; m_size <= cfg_size;
        m_pp <= cfg_pbase; m_pb <= cfg_pbase; m_mp <= cfg_mbase; m_mb <= cfg_mbase;
        m_rem  <= (cfg_count == 0) ? (1 << CW) : int'(cfg_count);
        m_load <= (cfg_count == 0) ? (1 << CW) : int'(cfg_count);
        m_run <= 1'b1; m_done <= 1'b0; m_err <= 1'b0;
      end
      case (m_ph)
        0: if (m_run && req_i) m_ph <= 1;
        1: m_ph <= 2;
        2: if (bus_ready) begin
             if (bus_err) begin m_err <= 1'b1; m_run <= 1'b0; m_ph <= 0; end
             else begin
               m_data <= data_of(m_dir ? m_mp : m_pp);
               m_ack  <= 1'b1;
               m_ph   <= 3;
             end
           end
        default: if (bus_ready) begin
             m_ph <= 0;
             if (bus_err) begin m_err <= 1'b1; m_run <= 1'b0; end
             else if (m_rem == 1 && m_circ) begin
               m_rem <= m_load; m_pp <= m_pb; m_mp <= m_mb;
             end else begin
               m_rem <= m_rem - 1;
               if (m_pinc) m_pp <= m_pp + stepb(m_size);
               if (m_minc) m_mp <= m_mp + stepb(m_size);
               if (m_rem == 1) begin m_done <= 1'b1; m_run <= 1'b0; end
             end
           end
      endcase
    end
  end

  // ---------------- compare ----------------
  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp,
                     input string what);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  int acks = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R1", bus_valid, (m_ph == 2 || m_ph == 3), "bus_valid");
      if (m_ph == 2 || m_ph == 3) begin
        chk("R1", bus_write, (m_ph == 3), "bus_write");
        chk("R5", bus_size, m_size, "bus_size");
        if (m_ph == 2) chk("R4", bus_addr, m_dir ? m_mp : m_pp, "read address");
        else begin
          chk("R4", bus_addr, m_dir ? m_pp : m_mp, "write address");
          chk("R1", bus_wdata, m_data, "write data");
        end
      end
      chk("R9", ack_o, m_ack, "ack_o");
      chk("R6", done_o, m_done, "done_o");
      chk("R8", err_o, m_err, "err_o");
      if (ack_o) acks++;
    end
  end

  // ---------------- stimulus ----------------
  task automatic enable(input logic dir, input logic pinc, input logic minc,
                        input logic [1:0] size, input logic circ, input int cnt,
                        input logic [AW-1:0] pb, input logic [AW-1:0] mb);
    cfg_en = 1'b0;
    @(negedge clk);
    cfg_dir = dir; cfg_pinc = pinc; cfg_minc = minc; cfg_size = size;
    cfg_circ = circ; cfg_count = CW'(cnt); cfg_pbase = pb; cfg_mbase = mb;
    cfg_en = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic serve(input int n);
    for (int k = 0; k < n; k++) begin
      req_i = 1'b1;
      for (int t = 0; t < 40; t++) begin
        @(negedge clk);
        if (ack_o || m_err) break;
      end
      req_i = 1'b0;
      repeat (3) @(negedge clk);
    end
  endtask

  task automatic main_seq();
    int a0;
    rst_n = 1'b0; cfg_en = 0; cfg_dir = 0; cfg_pinc = 0; cfg_minc = 0; cfg_size = 0;
    cfg_circ = 0; cfg_count = 0; cfg_pbase = 0; cfg_mbase = 0; req_i = 0;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10", {bus_valid, ack_o, done_o, err_o}, 4'b0000, "outputs in reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R10", {bus_valid, ack_o, done_o, err_o}, 4'b0000, "outputs after reset");

    // R4 R5 R6: one-shot, peripheral to memory, halfword, fixed peripheral pointer
    enable(1'b0, 1'b0, 1'b1, 2'd1, 1'b0, 4, 32'h4000_0010, 32'h2000_0100);
    serve(4);
    chk("R6", done_o, 1'b1, "done after last item");
    a0 = acks;
    serve(2);  // requests after completion are ignored
    chk("R6", acks, a0, "ack count after completion");

    // R7 R11 R3: circular, memory to peripheral, byte, wait states
    rdy_rand = 1'b1;
    enable(1'b1, 1'b1, 1'b1, 2'd0, 1'b1, 3, 32'h4001_0000, 32'h2000_0200);
    serve(2);
    cfg_pbase = 32'h5555_0000; cfg_size = 2'd2; cfg_count = 1;  // R11: ignored while enabled
    serve(5);
    chk("R7", done_o, 1'b0, "no done in circular mode");
    rdy_rand = 1'b0;

    // R6 R2: count zero means 2**CW items, request held high
    enable(1'b0, 1'b1, 1'b1, 2'd2, 1'b0, 0, 32'h4002_0000, 32'h2000_1000);
    a0 = acks;
    req_i = 1'b1;
    for (int t = 0; t < 2000 && !done_o; t++) @(negedge clk);
    req_i = 1'b0;
    repeat (3) @(negedge clk);
    chk("R6", acks - a0, 1 << CW, "items for zero count");

    // R8 R9: read-phase error
    enable(1'b0, 1'b1, 1'b1, 2'd1, 1'b1, 5, 32'h4003_0000, 32'h2000_2000);
    err_arm = 1'b1; err_ph = 2;
    a0 = acks;
    serve(1);
    err_arm = 1'b0;
    chk("R8", err_o, 1'b1, "error flag on read error");
    chk("R9", acks, a0, "no ack on read error");
    serve(1);
    chk("R8", acks, a0, "stopped after error");

    // R8: write-phase error, flags cleared by re-enable
    enable(1'b1, 1'b1, 1'b0, 2'd0, 1'b0, 5, 32'h4004_0000, 32'h2000_3000);
    chk("R8", err_o, 1'b0, "error cleared on enable");
    serve(1);
    err_arm = 1'b1; err_ph = 3;
    a0 = acks;
    serve(1);
    err_arm = 1'b0;
    chk("R9", acks - a0, 1, "ack before write error");
    chk("R8", err_o, 1'b1, "error flag on write error");

    // R12 R5: size code 3 steps by 4, disable stops new items
    enable(1'b0, 1'b1, 1'b1, 2'd3, 1'b1, 7, 32'h4005_0000, 32'h2000_4000);
    req_i = 1'b1;
    repeat (20) @(negedge clk);
    cfg_en = 1'b0;
    repeat (6) @(negedge clk);
    a0 = acks;
    repeat (10) @(negedge clk);
    chk("R12", acks, a0, "no items after disable");
    chk("R12", bus_valid, 1'b0, "bus idle after disable");
    req_i = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    fork
      main_seq();
      begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule